// File: doc/BRIEF.md
# Markov Transition Pair Test

This block screens a multi-line raw noise bus for first-order temporal correlation. On every line, valid samples are taken two at a time as consecutive, non-overlapping pairs. A pair whose two bits differ is a switching pair. A pair whose bits are equal is a repeating pair. The block counts switching pairs over a window. An ideal source switches in about half of its pairs. Too few switching pairs means the stream is clustered, for example because it is oversampled. Too many means it oscillates in a regular way.

A window-end pulse, driven from outside, closes each window and triggers the judgement. A scope input chooses how the judgement is made. In aggregate mode, the switching counts of all lines are summed and the sum is compared with the thresholds. In per-line mode, each line is compared with the thresholds on its own, so a single failing line is detected. The verdict comes out as one-cycle fail-high and fail-low pulses. The block also reports the score of the last window and the highest score seen since the last clear. Any pair left half-finished at a window end is discarded, so no pair spans two windows.

Top module: `markov_pair_test`

## Requirements
- R1: After reset, `fail_hi_o` and `fail_lo_o` are 0, and `test_cnt_o` and `hi_mark_o` are 0.
- R2: A pair phase toggles on each cycle with `sample_vld_i` high. Cycles with `sample_vld_i` low leave the phase and the counts unchanged. The first valid sample of a window (phase 0) stores a bit per line. The next valid sample (phase 1) completes the pair, and the line's count increments when the stored bit and the new bit differ.
- R3: With `scope_all_i` = 1, the score of a window is the sum of the per-line switching counts. The score appears on `test_cnt_o` in the cycle after `window_end_i`.
- R4: With `scope_all_i` = 0, the score is the largest per-line count. `fail_hi_o` pulses if any line count is greater than `thr_hi_i`. `fail_lo_o` pulses if any line count is less than `thr_lo_i`.
- R5: With `scope_all_i` = 1, `fail_hi_o` pulses when the sum is strictly greater than `thr_hi_i`, and `fail_lo_o` pulses when the sum is strictly less than `thr_lo_i`. A sum equal to either threshold raises no flag.
- R6: Fail flags are high for exactly the one cycle that follows a `window_end_i` cycle taken while the block is active and not clearing. At all other times they are low.
- R7: `window_end_i` zeroes the counts and the pair phase for the next window. A pair completed in the window-end cycle itself is counted. A first bit still waiting for its partner at the window end is dropped.
- R8: While `clear_i` = 1 or `active_i` = 0, the counts, the phase, `test_cnt_o` and `hi_mark_o` go to 0 on the next edge, and no fail flag is raised.
- R9: `hi_mark_o` holds the largest window score seen since the last clear or deactivation. It never decreases while the block is active.
- R10: A per-line count saturates at 2^CNT_W-1 and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| active_i | input | 1 | Test enable. When low, the block holds its state at zero |
| clear_i | input | 1 | Synchronous clear of all counters and results |
| scope_all_i | input | 1 | 1: aggregate score over all lines. 0: per-line score |
| thr_hi_i | input | SUM_W | Upper limit on the switching count |
| thr_lo_i | input | SUM_W | Lower limit on the switching count |
| sample_i | input | LINES | One noise bit per line |
| sample_vld_i | input | 1 | Qualifies `sample_i` |
| window_end_i | input | 1 | Closes the window and triggers evaluation |
| fail_hi_o | output | 1 | One-cycle pulse: too many switching pairs |
| fail_lo_o | output | 1 | One-cycle pulse: too few switching pairs |
| test_cnt_o | output | SUM_W | Score of the last evaluated window |
| hi_mark_o | output | SUM_W | Highest score since the last clear |

## Verification
The bench builds the block with four lines and CNT_W = 5. A line therefore saturates after 31 switching pairs, which takes 62 valid samples, so the saturation limit can be reached inside a short directed window. With these values the 7-bit aggregate score reaches 124, which exercises the upper part of the threshold range in both scopes. The random windows have irregular lengths and gaps between valid samples, so they cover odd-length windows that leave a half-finished pair. They also switch scope and thresholds between windows.

// File: rtl/markov_pkg.sv
package markov_pkg;

  // Scoring scope selected by the scope input.
  typedef enum logic {
    SCOPE_LINE = 1'b0,
    SCOPE_ALL  = 1'b1
  } scope_e;

  // Pair phase: waiting for the first or for the second bit of a pair.
  typedef enum logic {
    PH_FIRST  = 1'b0,
    PH_SECOND = 1'b1
  } pair_phase_e;

endpackage

// File: rtl/mkv_lane.sv
// Per-line pair scorer: stores the first bit of a pair and counts
// switching pairs with a saturating counter.
module mkv_lane #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             restart_i,
  input  logic             vld_i,
  input  logic             second_i,
  input  logic             bit_i,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic [CNT_W-1:0] cnt_q_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             first_q, first_d, first_en;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_step;
  logic             cnt_en;
  logic             is_switch;

  always_comb begin
    first_en  = flush_i | (vld_i & ~second_i);
    first_d   = flush_i ? 1'b0 : bit_i;
    is_switch = vld_i & second_i & (first_q ^ bit_i);
    cnt_step  = cnt_q;
    if (is_switch && (cnt_q != CNT_MAX)) begin
      cnt_step = cnt_q + 1'b1;
    end
    cnt_en = flush_i | restart_i | is_switch;
    cnt_d  = (flush_i | restart_i) ? '0 : cnt_step;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= 1'b0;
    end else if (first_en) begin
      first_q <= first_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_nxt_o = cnt_step;
  assign cnt_q_o   = cnt_q;

endmodule

// File: rtl/mkv_score.sv
// Combinational reduction of the per-line counts into a score and verdicts.
module mkv_score
  import markov_pkg::*;
#(
  parameter int unsigned LINES = 4,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SUM_W = CNT_W + $clog2(LINES)
) (
  input  logic [LINES-1:0][CNT_W-1:0] cnt_i,
  input  scope_e                      scope_i,
  input  logic [SUM_W-1:0]            thr_hi_i,
  input  logic [SUM_W-1:0]            thr_lo_i,
  output logic [SUM_W-1:0]            score_o,
  output logic                        over_o,
  output logic                        under_o
);

  logic [LINES-1:0] line_over, line_under;
  logic [SUM_W-1:0] sum, peak;

  for (genvar g = 0; g < LINES; g++) begin : g_line_cmp
    logic [SUM_W-1:0] wide;
    assign wide          = SUM_W'(cnt_i[g]);
    assign line_over[g]  = wide > thr_hi_i;
    assign line_under[g] = wide < thr_lo_i;
  end

  always_comb begin
    sum  = '0;
    peak = '0;
    for (int i = 0; i < LINES; i++) begin
      sum = sum + SUM_W'(cnt_i[i]);
      if (SUM_W'(cnt_i[i]) > peak) begin
        peak = SUM_W'(cnt_i[i]);
      end
    end
  end

  always_comb begin
    if (scope_i == SCOPE_ALL) begin
      score_o = sum;
      over_o  = sum > thr_hi_i;
      under_o = sum < thr_lo_i;
    end else begin
      score_o = peak;
      over_o  = |line_over;
      under_o = |line_under;
    end
  end

endmodule

// File: rtl/mkv_report.sv
// Registered result stage: fail pulses, last score and high watermark.
module mkv_report #(
  parameter int unsigned SUM_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             eval_i,
  input  logic [SUM_W-1:0] score_i,
  input  logic             over_i,
  input  logic             under_i,
  output logic             fail_hi_o,
  output logic             fail_lo_o,
  output logic [SUM_W-1:0] test_cnt_o,
  output logic [SUM_W-1:0] hi_mark_o
);

  logic             fhi_q, fhi_d, flo_q, flo_d;
  logic [SUM_W-1:0] tc_q, tc_d, hm_q, hm_d;
  logic             res_en;

  always_comb begin
    fhi_d  = 1'b0;
    flo_d  = 1'b0;
    tc_d   = tc_q;
    hm_d   = hm_q;
    res_en = flush_i | eval_i;
    if (flush_i) begin
      tc_d = '0;
      hm_d = '0;
    end else if (eval_i) begin
      fhi_d = over_i;
      flo_d = under_i;
      tc_d  = score_i;
      if (score_i > hm_q) begin
        hm_d = score_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fhi_q <= 1'b0;
      flo_q <= 1'b0;
    end else begin
      fhi_q <= fhi_d;
      flo_q <= flo_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tc_q <= '0;
      hm_q <= '0;
    end else if (res_en) begin
      tc_q <= tc_d;
      hm_q <= hm_d;
    end
  end

  assign fail_hi_o  = fhi_q;
  assign fail_lo_o  = flo_q;
  assign test_cnt_o = tc_q;
  assign hi_mark_o  = hm_q;

endmodule

// File: rtl/markov_pair_test.sv
// Windowed transition-pair health test over a multi-line noise bus.
module markov_pair_test
  import markov_pkg::*;
#(
  parameter int unsigned LINES = 4,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned SUM_W = CNT_W + $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             clear_i,
  input  logic             scope_all_i,
  input  logic [SUM_W-1:0] thr_hi_i,
  input  logic [SUM_W-1:0] thr_lo_i,
  input  logic [LINES-1:0] sample_i,
  input  logic             sample_vld_i,
  input  logic             window_end_i,
  output logic             fail_hi_o,
  output logic             fail_lo_o,
  output logic [SUM_W-1:0] test_cnt_o,
  output logic [SUM_W-1:0] hi_mark_o
);

  logic        flush, eval;
  pair_phase_e phase_q, phase_d;
  logic        phase_en;

  logic [LINES-1:0][CNT_W-1:0] lane_cnt_nxt, lane_cnt_q;
  logic [SUM_W-1:0]            score;
  logic                        over, under;

  assign flush = clear_i | ~active_i;
  assign eval  = window_end_i & ~flush;

  // Pair phase: toggles per valid sample, forced back at window end or flush.
  always_comb begin
    phase_en = flush | window_end_i | sample_vld_i;
    if (flush || window_end_i) begin
      phase_d = PH_FIRST;
    end else begin
      phase_d = (phase_q == PH_FIRST) ? PH_SECOND : PH_FIRST;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_FIRST;
    end else if (phase_en) begin
      phase_q <= phase_d;
    end
  end

  for (genvar g = 0; g < LINES; g++) begin : g_lane
    mkv_lane #(
      .CNT_W(CNT_W)
    ) i_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .flush_i  (flush),
      .restart_i(window_end_i),
      .vld_i    (sample_vld_i & ~flush),
      .second_i (phase_q == PH_SECOND),
      .bit_i    (sample_i[g]),
      .cnt_nxt_o(lane_cnt_nxt[g]),
      .cnt_q_o  (lane_cnt_q[g])
    );
  end

  mkv_score #(
    .LINES(LINES),
    .CNT_W(CNT_W),
    .SUM_W(SUM_W)
  ) i_score (
    .cnt_i   (lane_cnt_nxt),
    .scope_i (scope_e'(scope_all_i)),
    .thr_hi_i(thr_hi_i),
    .thr_lo_i(thr_lo_i),
    .score_o (score),
    .over_o  (over),
    .under_o (under)
  );

  mkv_report #(
    .SUM_W(SUM_W)
  ) i_report (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush),
    .eval_i    (eval),
    .score_i   (score),
    .over_i    (over),
    .under_i   (under),
    .fail_hi_o (fail_hi_o),
    .fail_lo_o (fail_lo_o),
    .test_cnt_o(test_cnt_o),
    .hi_mark_o (hi_mark_o)
  );

endmodule

// File: rtl/mkv_checker.sv
module mkv_checker #(
  parameter int unsigned LINES = 4,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SUM_W = CNT_W + $clog2(LINES)
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        active_i,
  input logic                        clear_i,
  input logic                        window_end_i,
  input logic                        fail_hi_o,
  input logic                        fail_lo_o,
  input logic [SUM_W-1:0]            test_cnt_o,
  input logic [SUM_W-1:0]            hi_mark_o,
  input logic [LINES-1:0][CNT_W-1:0] lane_cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // R6
  fail_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_hi_o || fail_lo_o) |-> $past(window_end_i && active_i && !clear_i));

  // R6
  fail_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !window_end_i |=> (!fail_hi_o && !fail_lo_o));

  // R8
  flush_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i || !active_i) |=> (test_cnt_o == '0 && hi_mark_o == '0 && !fail_hi_o && !fail_lo_o));

  // R9
  mark_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_mark_o >= test_cnt_o);

  // R9
  mark_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !clear_i) |=> hi_mark_o >= $past(hi_mark_o));

  // R7
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    window_end_i |=> lane_cnt == '0);

  for (genvar g = 0; g < LINES; g++) begin : g_sat
    // R10
    sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lane_cnt[g] == CNT_MAX && !window_end_i && active_i && !clear_i) |=> lane_cnt[g] == CNT_MAX);
  end

endmodule

bind markov_pair_test mkv_checker #(
  .LINES(LINES),
  .CNT_W(CNT_W)
) i_mkv_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .active_i    (active_i),
  .clear_i     (clear_i),
  .window_end_i(window_end_i),
  .fail_hi_o   (fail_hi_o),
  .fail_lo_o   (fail_lo_o),
  .test_cnt_o  (test_cnt_o),
  .hi_mark_o   (hi_mark_o),
  .lane_cnt    (lane_cnt_q)
);

// File: tb/test_markov_pair_test.sv
module test_markov_pair_test;

  localparam int LINES = 4;
  localparam int CNT_W = 5;
  localparam int SUM_W = CNT_W + $clog2(LINES);
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic             clk, rst_n;
  logic             active, clear, scope_all, vld, wend;
  logic [SUM_W-1:0] thr_hi, thr_lo;
  logic [LINES-1:0] smp;
  logic             fail_hi, fail_lo;
  logic [SUM_W-1:0] test_cnt, hi_mark;

  int errors = 0;
  int checks = 0;
  string tag = "R1";

  // bench model state
  int m_cnt [LINES];
  bit m_first [LINES];
  bit m_phase;
  bit e_fh, e_fl;
  int e_tc, e_hm;

  markov_pair_test #(.LINES(LINES), .CNT_W(CNT_W)) i_markov_pair_test (
    .clk_i(clk), .rst_ni(rst_n), .active_i(active), .clear_i(clear),
    .scope_all_i(scope_all), .thr_hi_i(thr_hi), .thr_lo_i(thr_lo),
    .sample_i(smp), .sample_vld_i(vld), .window_end_i(wend),
    .fail_hi_o(fail_hi), .fail_lo_o(fail_lo),
    .test_cnt_o(test_cnt), .hi_mark_o(hi_mark));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s/%s: actual=%0d expected=%0d", tag, req, act, exp);
    end
  endtask

  task automatic model(input bit v, input logic [LINES-1:0] b, input bit we);
    int nx [LINES];
    int sum, mx;
    bit ah, al;
    if (clear || !active) begin
      m_phase = 0;
      for (int i = 0; i < LINES; i++) begin m_cnt[i] = 0; m_first[i] = 0; end
      e_fh = 0; e_fl = 0; e_tc = 0; e_hm = 0;
      return;
    end
    for (int i = 0; i < LINES; i++) begin
      nx[i] = m_cnt[i];
      if (v && m_phase && (m_first[i] != b[i]) && m_cnt[i] < CMAX) nx[i]++;
      if (v && !m_phase) m_first[i] = b[i];
    end
    if (we) begin
      sum = 0; mx = 0; ah = 0; al = 0;
      for (int i = 0; i < LINES; i++) begin
        sum += nx[i];
        if (nx[i] > mx) mx = nx[i];
        if (nx[i] > int'(thr_hi)) ah = 1;
        if (nx[i] < int'(thr_lo)) al = 1;
      end
      if (scope_all) begin
        e_fh = sum > int'(thr_hi); e_fl = sum < int'(thr_lo); e_tc = sum;
      end else begin
        e_fh = ah; e_fl = al; e_tc = mx;
      end
      if (e_tc > e_hm) e_hm = e_tc;
      for (int i = 0; i < LINES; i++) m_cnt[i] = 0;
      m_phase = 0;
    end else begin
      e_fh = 0; e_fl = 0;
      for (int i = 0; i < LINES; i++) m_cnt[i] = nx[i];
      m_phase = m_phase ^ v;
    end
  endtask

  task automatic step(input bit v, input logic [LINES-1:0] b, input bit we);
    @(negedge clk);
    vld = v; smp = b; wend = we;
    model(v, b, we);
    @(posedge clk);
    #1;
    check(scope_all ? "R5" : "R4", int'(fail_hi), int'(e_fh));
    check(scope_all ? "R5" : "R4", int'(fail_lo), int'(e_fl));
    check(scope_all ? "R3" : "R4", int'(test_cnt), e_tc);
    check("R9", int'(hi_mark), e_hm);
  endtask

  // n valid samples alternating between pattern a and ~a; last one ends window
  task automatic alt_window(input int n, input logic [LINES-1:0] a);
    for (int k = 0; k < n; k++) step(1'b1, (k % 2 == 0) ? a : ~a, k == n - 1);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 0; active = 0; clear = 0; scope_all = 1; vld = 0; wend = 0;
    smp = '0; thr_hi = 7'd20; thr_lo = 7'd4;
    m_phase = 0; e_fh = 0; e_fl = 0; e_tc = 0; e_hm = 0;
    for (int i = 0; i < LINES; i++) begin m_cnt[i] = 0; m_first[i] = 0; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    tag = "R1";
    check("R1", int'(fail_hi), 0); check("R1", int'(fail_lo), 0);
    check("R1", int'(test_cnt), 0); check("R1", int'(hi_mark), 0);
    rst_n = 1;
    active = 1;
    step(1'b0, '0, 1'b0);

    // R2/R5: all pairs switching -> 8 pairs x 4 lines = 32 > 20
    tag = "R2";
    alt_window(16, 4'hF);
    // R6: pulse drops in following idle cycles
    tag = "R6";
    step(1'b0, '0, 1'b0);
    step(1'b0, '0, 1'b0);
    // R2: invalid cycles interleaved do not disturb pairing
    tag = "R2";
    for (int k = 0; k < 12; k++) begin
      step(1'b1, (k % 2 == 0) ? 4'h5 : 4'hA, 1'b0);
      step(1'b0, 4'hF, 1'b0);
    end
    step(1'b0, '0, 1'b1);

    // R5: constant stream -> 0 < 4 low fail
    tag = "R5";
    for (int k = 0; k < 10; k++) step(1'b1, 4'h3, k == 9);
    // R5: equality at both thresholds -> no flag (8 switching pairs)
    thr_hi = 7'd8; thr_lo = 7'd8;
    alt_window(4, 4'hF);
    // R7: odd window leaves a dangling first bit, next window starts fresh
    tag = "R7";
    thr_hi = 7'd20; thr_lo = 7'd0;
    step(1'b1, 4'h0, 1'b0);
    step(1'b1, 4'hF, 1'b0);
    step(1'b1, 4'h0, 1'b1);
    step(1'b1, 4'hF, 1'b0);
    step(1'b1, 4'hF, 1'b1);

    // R4: per-line scope, only line 2 oscillates
    tag = "R4";
    scope_all = 0; thr_hi = 7'd5; thr_lo = 7'd0;
    alt_window(16, 4'h4);
    thr_hi = 7'd31; thr_lo = 7'd1;
    alt_window(16, 4'h4);

    // R10: saturation of line counts at CMAX
    tag = "R10";
    thr_hi = 7'd127; thr_lo = 7'd0;
    alt_window(90, 4'hF);
    scope_all = 1;
    alt_window(90, 4'hF);

    // R8: clear mid-window, then deactivate with a window end
    tag = "R8";
    alt_window(6, 4'hF);
    for (int k = 0; k < 3; k++) step(1'b1, k[0] ? 4'hF : 4'h0, 1'b0);
    clear = 1;
    step(1'b1, 4'h0, 1'b1);
    clear = 0;
    step(1'b1, 4'hF, 1'b0);
    step(1'b1, 4'h0, 1'b1);
    active = 0;
    step(1'b1, 4'hF, 1'b1);
    active = 1;
    step(1'b0, '0, 1'b0);

    // random mix
    tag = "R3";
    for (int n = 0; n < 3000; n++) begin
      bit v, we;
      v  = ($urandom % 4) != 0;
      we = ($urandom % 40) == 0;
      if (($urandom % 500) == 0) clear = 1;
      step(v, LINES'($urandom), we);
      clear = 0;
      if (we) begin
        scope_all = $urandom % 2;
        thr_hi = SUM_W'($urandom % 40);
        thr_lo = SUM_W'($urandom % 10);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule